// File: doc/BRIEF.md
# Overtemperature Alarm Controller with Fault Queue

This block turns a stream of signed 16-bit temperature results into an overtemperature alarm. Each result arrives with a one-cycle conversion-done strobe. The block compares the result against two programmable limits: a trip limit and a lower hysteresis limit. A consecutive-fault queue of 1, 2, 4 or 6 conversions has to fill before the alarm changes state, so a single noisy sample does not toggle it.

In comparator mode the alarm acts as a thermostat. It sets when the temperature exceeds the trip limit and clears when the temperature goes under the hysteresis limit. In interrupt mode the alarm latches until any register read or a shutdown entry. The condition that arms the next event alternates: first a rise above the trip limit, then a drop below the hysteresis limit, then a rise again, and so on. The open-drain output pin is modelled as an active-high pull-low enable, and a polarity control selects whether that pin is active low or active high.

The temperature converter and the serial bus are outside this block. The surrounding logic provides the limits and the configuration bits, plus single-cycle pulses for register reads and for entry into shutdown.

Top module: `thermo_alarm`

## Requirements
- R1: After reset the alarm is deasserted, the fault count is empty and the interrupt arming waits for a rise. With the default active-low polarity, `pin_low_o` is 0.
- R2: In comparator mode, once the queue is satisfied, the alarm sets on results strictly greater than the trip limit and clears on results strictly less than the hysteresis limit. A result equal to either limit is not a fault.
- R3: All comparisons treat the temperature and both limits as signed two's complement. For example, 8000h and FF00h are below a limit of 4B00h.
- R4: In interrupt mode the alarm sets when the armed condition is met. It then stays set, whatever later conversions show, until a `reg_read_i` pulse clears it. The clear is visible in the following cycle.
- R5: In interrupt mode each trip swaps the armed condition. After a trip on rising above the trip limit, only a result below the hysteresis limit can trip next, and the reverse applies after a trip on falling.
- R6: `queue_sel_i` selects the number of consecutive faulting conversions needed for a change: 0→1, 1→2, 2→4, 3→6. A conversion that is not a fault empties the count.
- R7: With `act_high_i`=0, `pin_low_o` is 1 exactly while the alarm is asserted. With `act_high_i`=1, `pin_low_o` is 1 exactly while the alarm is deasserted.
- R8: A `shdn_enter_i` pulse clears the alarm in interrupt mode. In comparator mode it has no effect.
- R9: In comparator mode `reg_read_i` has no effect on the alarm.
- R10: Any change of `int_mode_i` clears the alarm and the fault count, and arms interrupt mode for a rise.
- R11: State changes only on cycles with `conv_done_i` high, apart from clears. The new alarm value appears on the cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| conv_done_i | input | 1 | One-cycle strobe: `temp_i` holds a new result |
| temp_i | input | 16 | Signed temperature result |
| trip_lim_i | input | 16 | Signed trip limit |
| hyst_lim_i | input | 16 | Signed hysteresis limit |
| int_mode_i | input | 1 | 0 comparator, 1 interrupt mode |
| act_high_i | input | 1 | Output polarity: 0 active low, 1 active high |
| queue_sel_i | input | 2 | Fault queue depth select |
| reg_read_i | input | 1 | Pulse: a register read happened |
| shdn_enter_i | input | 1 | Pulse: shutdown was entered |
| alarm_o | output | 1 | Logical alarm state |
| pin_low_o | output | 1 | Open-drain pull-low enable |

## Verification
Every result comes from a single register stage. A strobe, read, shutdown pulse or mode change sampled on one rising edge is visible on `alarm_o` right after that edge. `pin_low_o` follows `alarm_o` and the polarity input combinationally. The bench drives each stimulus, waits exactly one rising edge, and samples a short delay after that edge. It compares against a model built from the requirements, stepping through all mode, polarity and depth combinations. It also runs directed sequences with exact expected values for the equal-to-limit, negative-value, alternation and queue-depth cases.

// File: rtl/thermo_alarm_pkg.sv
package thermo_alarm_pkg;
  localparam int unsigned QSEL_W = 2;
  localparam int unsigned QCNT_W = 3;

  typedef enum logic {
    ARM_RISE = 1'b0,
    ARM_FALL = 1'b1
  } arm_e;

  function automatic logic [QCNT_W-1:0] queue_depth(input logic [QSEL_W-1:0] sel);
    unique case (sel)
      2'd0:    return QCNT_W'(1);
      2'd1:    return QCNT_W'(2);
      2'd2:    return QCNT_W'(4);
      default: return QCNT_W'(6);
    endcase
  endfunction
endpackage

// File: rtl/ta_limit_cmp.sv
module ta_limit_cmp #(
  parameter int unsigned W          = 16,
  parameter bit          SIGNED_CMP = 1'b1
) (
  input  logic [W-1:0] temp_i,
  input  logic [W-1:0] trip_lim_i,
  input  logic [W-1:0] hyst_lim_i,
  output logic         above_trip_o,
  output logic         below_hyst_o
);
  if (SIGNED_CMP) begin : g_signed
    assign above_trip_o = $signed(temp_i) > $signed(trip_lim_i);
    assign below_hyst_o = $signed(temp_i) < $signed(hyst_lim_i);
  end else begin : g_unsigned
    assign above_trip_o = temp_i > trip_lim_i;
    assign below_hyst_o = temp_i < hyst_lim_i;
  end
endmodule

// File: rtl/ta_fault_queue.sv
module ta_fault_queue
  import thermo_alarm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              evt_i,
  input  logic              fault_i,
  input  logic [QSEL_W-1:0] qsel_i,
  output logic              hit_o
);
  logic [QCNT_W-1:0] cnt_q;
  logic [QCNT_W-1:0] depth_m1;

  assign depth_m1 = queue_depth(qsel_i) - QCNT_W'(1);
  // >= keeps a shrinking depth select from wrapping the count
  assign hit_o    = evt_i & fault_i & (cnt_q >= depth_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (evt_i) begin
      if (fault_i && !hit_o) cnt_q <= cnt_q + QCNT_W'(1);
      else                   cnt_q <= '0;
    end
  end
endmodule

// File: rtl/ta_alarm_ctrl.sv
module ta_alarm_ctrl
  import thermo_alarm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic int_mode_i,
  input  logic above_trip_i,
  input  logic below_hyst_i,
  input  logic reg_read_i,
  input  logic shdn_enter_i,
  input  logic hit_i,
  output logic fault_o,
  output logic mode_chg_o,
  output logic alarm_o
);
  arm_e arm_q;
  logic alarm_q;
  logic mode_q;
  logic want_fall;
  logic int_clr;

  assign mode_chg_o = int_mode_i ^ mode_q;
  // which edge counts as a fault: falling after a set (thermostat) or per arming
  assign want_fall  = int_mode_i ? (arm_q == ARM_FALL) : alarm_q;
  // latched interrupt holds off evaluation until cleared
  assign fault_o    = ~(int_mode_i & alarm_q) &
                      (want_fall ? below_hyst_i : above_trip_i);
  assign int_clr    = int_mode_i & (reg_read_i | shdn_enter_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alarm_q <= 1'b0;
      arm_q   <= ARM_RISE;
      mode_q  <= 1'b0;
    end else begin
      mode_q <= int_mode_i;
      if (mode_chg_o) begin
        alarm_q <= 1'b0;
        arm_q   <= ARM_RISE;
      end else if (int_mode_i) begin
        alarm_q <= (alarm_q & ~int_clr) | hit_i;
        if (hit_i) arm_q <= (arm_q == ARM_RISE) ? ARM_FALL : ARM_RISE;
      end else begin
        alarm_q <= alarm_q ^ hit_i;
      end
    end
  end

  assign alarm_o = alarm_q;
endmodule

// File: rtl/thermo_alarm.sv
module thermo_alarm
  import thermo_alarm_pkg::*;
#(
  parameter int unsigned TEMP_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              conv_done_i,
  input  logic [TEMP_W-1:0] temp_i,
  input  logic [TEMP_W-1:0] trip_lim_i,
  input  logic [TEMP_W-1:0] hyst_lim_i,
  input  logic              int_mode_i,
  input  logic              act_high_i,
  input  logic [1:0]        queue_sel_i,
  input  logic              reg_read_i,
  input  logic              shdn_enter_i,
  output logic              alarm_o,
  output logic              pin_low_o
);
  logic above_trip, below_hyst;
  logic fault, hit, mode_chg, alarm;

  ta_limit_cmp #(.W(TEMP_W), .SIGNED_CMP(1'b1)) u_cmp (
    .temp_i       (temp_i),
    .trip_lim_i   (trip_lim_i),
    .hyst_lim_i   (hyst_lim_i),
    .above_trip_o (above_trip),
    .below_hyst_o (below_hyst)
  );

  ta_fault_queue u_queue (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (mode_chg),
    .evt_i   (conv_done_i),
    .fault_i (fault),
    .qsel_i  (queue_sel_i),
    .hit_o   (hit)
  );

  ta_alarm_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .int_mode_i   (int_mode_i),
    .above_trip_i (above_trip),
    .below_hyst_i (below_hyst),
    .reg_read_i   (reg_read_i),
    .shdn_enter_i (shdn_enter_i),
    .hit_i        (hit),
    .fault_o      (fault),
    .mode_chg_o   (mode_chg),
    .alarm_o      (alarm)
  );

  assign alarm_o   = alarm;
  // active low pulls the pin while asserted; active high pulls it while idle
  assign pin_low_o = alarm ^ act_high_i;
endmodule

// File: rtl/thermo_alarm_chk.sv
module thermo_alarm_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic conv_done_i,
  input logic int_mode_i,
  input logic act_high_i,
  input logic reg_read_i,
  input logic shdn_enter_i,
  input logic alarm_o,
  input logic pin_low_o
);
  assert_read_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_mode_i && $stable(int_mode_i) && reg_read_i && alarm_o) |=> !alarm_o);

  assert_shdn_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_mode_i && $stable(int_mode_i) && shdn_enter_i && alarm_o) |=> !alarm_o);

  assert_cmp_read_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!int_mode_i && $stable(int_mode_i) && alarm_o && !conv_done_i) |=> alarm_o);

  assert_hold_no_strobe_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!conv_done_i && !reg_read_i && !shdn_enter_i && $stable(int_mode_i)) |=> $stable(alarm_o));

  assert_rise_needs_strobe_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alarm_o) |-> $past(conv_done_i));

  assert_mode_change_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_mode_i != $past(int_mode_i)) |=> !alarm_o);

  assert_pin_active_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!act_high_i) |-> (pin_low_o == alarm_o));

  assert_pin_active_high_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_high_i) |-> (pin_low_o != alarm_o));
endmodule

bind thermo_alarm thermo_alarm_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .conv_done_i  (conv_done_i),
  .int_mode_i   (int_mode_i),
  .act_high_i   (act_high_i),
  .reg_read_i   (reg_read_i),
  .shdn_enter_i (shdn_enter_i),
  .alarm_o      (alarm_o),
  .pin_low_o    (pin_low_o)
);

// File: tb/thermo_alarm_tb_top.sv
module thermo_alarm_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] TRIP = 16'h5000;
  localparam logic [15:0] HYST = 16'h4B00;
  localparam logic [15:0] HOT  = 16'h6000;
  localparam logic [15:0] MID  = 16'h4C00;
  localparam logic [15:0] COLD = 16'h4000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic conv = 1'b0, rd = 1'b0, sd = 1'b0;
  logic [15:0] temp = 16'h0;
  logic mode = 1'b0, pol = 1'b0;
  logic [1:0] qsel = 2'd0;
  logic alarm, pin_low;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // requirement-derived reference state
  logic m_alarm = 1'b0, m_arm = 1'b0, m_prev = 1'b0;
  int   m_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  thermo_alarm dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .conv_done_i  (conv),
    .temp_i       (temp),
    .trip_lim_i   (TRIP),
    .hyst_lim_i   (HYST),
    .int_mode_i   (mode),
    .act_high_i   (pol),
    .queue_sel_i  (qsel),
    .reg_read_i   (rd),
    .shdn_enter_i (sd),
    .alarm_o      (alarm),
    .pin_low_o    (pin_low)
  );

  task automatic check(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int depth(input logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : (s == 2'd2) ? 4 : 6;
  endfunction

  task automatic model(input logic c, input logic [15:0] t, input logic r, input logic s);
    logic f, trip;
    if (mode != m_prev) begin
      m_cnt = 0; m_alarm = 1'b0; m_arm = 1'b0;
    end else begin
      trip = 1'b0;
      if (c) begin
        if (mode && m_alarm) f = 1'b0;
        else if (mode ? m_arm : m_alarm) f = ($signed(t) < $signed(HYST));
        else f = ($signed(t) > $signed(TRIP));
        if (f) begin
          if (m_cnt + 1 >= depth(qsel)) begin trip = 1'b1; m_cnt = 0; end
          else m_cnt++;
        end else m_cnt = 0;
      end
      if (mode) begin
        m_alarm = (m_alarm & ~(r | s)) | trip;
        if (trip) m_arm = ~m_arm;
      end else begin
        m_alarm = m_alarm ^ trip;
      end
    end
    m_prev = mode;
  endtask

  task automatic step(input logic c, input logic [15:0] t, input logic r, input logic s);
    conv = c; temp = t; rd = r; sd = s;
    @(posedge clk);
    model(c, t, r, s);
    #1;
    conv = 1'b0; rd = 1'b0; sd = 1'b0;
  endtask

  function automatic logic [15:0] pat(input int i);
    int k = i % 20;
    if (k < 8)  return (k == 3) ? TRIP : TRIP + 16'h0100;
    if (k < 10) return MID;
    if (k < 18) return (k == 13) ? HYST : HYST - 16'h0100;
    return MID;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(alarm, 1'b0, "R1");
    check(pin_low, 1'b0, "R1");
    rst_n = 1'b1;
    @(posedge clk); #1;
    check(alarm, 1'b0, "R1");

    // comparator, signed compares, equal-to-limit
    step(1, 16'h8000, 0, 0); check(alarm, 1'b0, "R3");
    step(1, 16'h5001, 0, 0); check(alarm, 1'b1, "R2");
    step(1, TRIP, 0, 0);     check(alarm, 1'b1, "R2");
    step(1, HYST, 0, 0);     check(alarm, 1'b1, "R2");
    step(1, 16'hFF00, 0, 0); check(alarm, 1'b0, "R3");

    // strobe gating, ignored read and shutdown in comparator mode
    repeat (3) begin step(0, HOT, 0, 0); check(alarm, 1'b0, "R11"); end
    step(1, HOT, 0, 0); check(alarm, 1'b1, "R11");
    step(0, HOT, 1, 0); check(alarm, 1'b1, "R9");
    step(0, HOT, 0, 1); check(alarm, 1'b1, "R8");

    // polarity
    check(pin_low, 1'b1, "R7");
    pol = 1'b1;
    step(0, HOT, 0, 0);  check(pin_low, 1'b0, "R7");
    step(1, COLD, 0, 0); check(alarm, 1'b0, "R2"); check(pin_low, 1'b1, "R7");
    pol = 1'b0;
    step(0, COLD, 0, 0); check(pin_low, 1'b0, "R7");

    // mode change clears alarm and count
    step(1, HOT, 0, 0); check(alarm, 1'b1, "R2");
    mode = 1'b1; qsel = 2'd1;
    step(0, HOT, 0, 0); check(alarm, 1'b0, "R10");
    step(1, HOT, 0, 0); check(alarm, 1'b0, "R6");
    mode = 1'b0;
    step(0, HOT, 0, 0); check(alarm, 1'b0, "R10");
    step(1, HOT, 0, 0); check(alarm, 1'b0, "R10");
    step(1, HOT, 0, 0); check(alarm, 1'b1, "R6");

    // interrupt latching and alternation
    mode = 1'b1; qsel = 2'd0;
    step(0, HOT, 0, 0);  check(alarm, 1'b0, "R10");
    step(1, HOT, 0, 0);  check(alarm, 1'b1, "R4");
    step(1, COLD, 0, 0); check(alarm, 1'b1, "R4");
    step(1, HOT, 0, 0);  check(alarm, 1'b1, "R4");
    step(0, HOT, 1, 0);  check(alarm, 1'b0, "R4");
    step(1, HOT, 0, 0);  check(alarm, 1'b0, "R5");
    step(1, COLD, 0, 0); check(alarm, 1'b1, "R5");
    step(0, COLD, 1, 0); check(alarm, 1'b0, "R4");
    step(1, COLD, 0, 0); check(alarm, 1'b0, "R5");
    step(1, HOT, 0, 0);  check(alarm, 1'b1, "R5");
    step(0, HOT, 0, 1);  check(alarm, 1'b0, "R8");

    // depth six with a broken streak
    mode = 1'b0; qsel = 2'd3;
    step(0, HOT, 0, 0); check(alarm, 1'b0, "R10");
    repeat (5) begin step(1, HOT, 0, 0); check(alarm, 1'b0, "R6"); end
    step(1, MID, 0, 0); check(alarm, 1'b0, "R6");
    repeat (5) begin step(1, HOT, 0, 0); check(alarm, 1'b0, "R6"); end
    step(1, HOT, 0, 0); check(alarm, 1'b1, "R6");

    // sweep all configurations against the model
    for (int cfg = 0; cfg < 16; cfg++) begin
      mode = cfg[3]; pol = cfg[2]; qsel = cfg[1:0];
      step(0, MID, 0, 0);
      check(alarm, m_alarm, mode ? "R4" : "R2");
      for (int i = 0; i < 60; i++) begin
        step((i % 9) != 4, pat(i), (i % 7) == 6, (i % 13) == 12);
        check(alarm, m_alarm, mode ? "R5" : "R6");
        check(pin_low, m_alarm ^ pol, "R7");
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule